// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs the management side of an Ethernet PHY link. Software places one 32-bit command word in a data register. When the controller is idle, that write starts a management frame on the MDC clock and the MDIO data line. The frame is a read or a write of one PHY register. The start code, opcode, PHY address, register address, turnaround and data fields all come from fixed bit positions of the command word. The 32 frame bits are sent exactly as written, most significant bit first, after a preamble of ones.

When the last MDC falling edge of the frame has passed, the controller sets a completion event bit, which software clears by writing a one to it. On a read frame, the 16 bits sampled from the PHY replace the low half of the data register. MDC runs only while a frame is in flight. Its half-period, in system clocks, is taken from a speed register field.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A write to the data register (csr_addr 0) while idle starts a frame. It is PRE_LEN (32) ones followed by the 32 bits of the written word, bit 31 first. Each new bit appears on mdio_o on an MDC falling edge; the first bit appears at the start.
- R2: The speed register (csr_addr 2) holds a field N in bits 6:1, and each MDC half-period lasts N system clocks; a field of zero acts as one. While no frame is in flight, MDC is low.
- R3: A frame whose word bits 29:28 are 10 is a read. For a read, mdio_oe is low during word bits 17 down to 0 (turnaround and data). A frame with any other opcode drives all of its bits. mdio_oe is low when idle.
- R4: On a read, mdio_i is sampled at each MDC rising edge of word bits 15 down to 0, first sample most significant. At completion these 16 bits replace data register bits 15:0, and bits 31:16 keep the written value.
- R5: After a frame that is not a read, the data register still reads the written word.
- R6: Completion sets bit 23 of the event register (csr_addr 1). The bit becomes visible in the clock after the final MDC falling edge.
- R7: Writing the event register with bit 23 set clears the event. Writing it with bit 23 clear leaves the event unchanged.
- R8: If completion and a clearing write fall in the same clock, the event ends up set.
- R9: A data register write while a frame is in flight is ignored. The frame on the wire and the data register are unaffected, and no second frame follows.
- R10: csr_rdata is registered. It shows the register selected by csr_addr one clock after the address is presented. The speed field reads back in bits 6:1, and the event reads back in bit 23.
- R11: After reset, the data and event registers read zero, the speed field reads DEF_HALF (2), and mdc and mdio_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select: 0 data, 1 event, 2 speed |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered read data for csr_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
Two things can change the completion event in the same clock: a frame finishing, which sets it, and a software write that clears it. The bench places a clearing write exactly on the clock of the last MDC falling edge. With the divider field at zero, that clock is 128 clocks after the launch. The bench then expects the event to read back as set, and a later clearing write to bring it to zero. A second overlap, a new data word written in the middle of a frame, is judged bit by bit. The scoreboard holds only the first frame's bits and reports any extra MDC edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W   = 32;
  localparam int DATA_W  = 16;
  localparam int EVT_BIT = 23;
  localparam int TA_HI   = 17;
  localparam int OP_HI   = 29;
  localparam int OP_LO   = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_EVENT = 2'd1,
    SEL_SPEED = 2'd2,
    SEL_NONE  = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             hit;

  assign hit       = run && (cnt_q == (half_div - ONE));
  assign rise_tick = hit && !mdc_q;
  assign fall_tick = hit && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // R2: MDC cannot change level unless the divider reached its limit
  assert_mdc_toggle_on_hit_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !hit) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int TOT   = PRE_LEN + CMD_W;
  localparam int POS_W = $clog2(TOT);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(TOT - 1);
  localparam logic [POS_W-1:0] REL_POS  = POS_W'(PRE_LEN + CMD_W - 1 - TA_HI);
  localparam logic [POS_W-1:0] CAP_POS  = POS_W'(PRE_LEN + CMD_W - DATA_W);
  localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);

  logic              busy_q;
  logic              rd_q;
  logic [DIV_W-1:0]  half_q;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  pos_nx;
  logic [TOT-1:0]    tx_sr;
  logic              oe_q;
  logic [DATA_W-1:0] rx_q;
  logic              rise_tick;
  logic              fall_tick;

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk       (clk),
    .rst       (rst),
    .run       (busy_q),
    .half_div  (half_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  assign pos_nx  = pos_q + POS_ONE;
  assign done    = busy_q && fall_tick && (pos_q == LAST_POS);
  assign busy    = busy_q;
  assign rx_data = rx_q;
  assign mdio_o  = tx_sr[TOT-1];
  assign mdio_oe = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      half_q <= DIV_W'(1);
      pos_q  <= '0;
      tx_sr  <= '1;
      oe_q   <= 1'b0;
      rx_q   <= '0;
    end else if (launch && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= (cmd[OP_HI:OP_LO] == OP_READ);
      half_q <= half_div;
      pos_q  <= '0;
      tx_sr  <= {{PRE_LEN{1'b1}}, cmd};
      oe_q   <= 1'b1;
    end else if (busy_q) begin
      if (rise_tick && rd_q && (pos_q >= CAP_POS))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (done) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          tx_sr  <= '1;
        end else begin
          pos_q <= pos_nx;
          tx_sr <= {tx_sr[TOT-2:0], 1'b1};
          oe_q  <= !(rd_q && (pos_nx >= REL_POS));
        end
      end
    end
  end

  assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !mdc);
  assert_oe_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !mdio_oe);
  assert_read_release_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && rd_q && (pos_q >= REL_POS)) |-> !mdio_oe);
  assert_write_drive_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !rd_q) |-> mdio_oe);
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int DEF_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic [1:0]        csr_addr,
  input  logic [CMD_W-1:0]  csr_wdata,
  output logic [CMD_W-1:0]  csr_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  output logic              launch,
  output logic [DIV_W-1:0]  half_div
);
  csr_sel_e         sel;
  logic [CMD_W-1:0] data_q;
  logic             evt_q;
  logic [DIV_W-1:0] speed_q;
  logic             clr;
  logic [CMD_W-1:0] rd_mux;

  assign sel      = csr_sel_e'(csr_addr);
  assign launch   = csr_wr && (sel == SEL_DATA) && !busy;
  assign clr      = csr_wr && (sel == SEL_EVENT) && csr_wdata[EVT_BIT];
  assign half_div = (speed_q == '0) ? DIV_W'(1) : speed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      evt_q   <= 1'b0;
      speed_q <= DIV_W'(DEF_HALF);
    end else begin
      if (launch)
        data_q <= csr_wdata;
      else if (done && (data_q[OP_HI:OP_LO] == OP_READ))
        data_q[DATA_W-1:0] <= rx_data;
      if (done)
        evt_q <= 1'b1;
      else if (clr)
        evt_q <= 1'b0;
      if (csr_wr && (sel == SEL_SPEED))
        speed_q <= csr_wdata[DIV_W:1];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DATA:  rd_mux = data_q;
      SEL_EVENT: rd_mux[EVT_BIT] = evt_q;
      SEL_SPEED: rd_mux[DIV_W:1] = speed_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else     csr_rdata <= rd_mux;
  end

  assert_event_set_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> evt_q);
  assert_event_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !done) |=> !evt_q);
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && (sel == SEL_DATA) && busy && !done) |=> $stable(data_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int DIV_W    = 6,
  parameter int DEF_HALF = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csr_wr,
  input  logic [1:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              busy;
  logic              done;
  logic              launch;
  logic [DIV_W-1:0]  half_div;
  logic [DATA_W-1:0] rx_data;

  mdio_csr #(.DIV_W(DIV_W), .DEF_HALF(DEF_HALF)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .busy      (busy),
    .done      (done),
    .rx_data   (rx_data),
    .launch    (launch),
    .half_div  (half_div)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .cmd      (csr_wdata),
    .half_div (half_div),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .done     (done),
    .rx_data  (rx_data),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0;
  logic [1:0]  csr_addr = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int vec_cnt = 0;
  int fail_cnt = 0;
  int rise_cnt = 0;
  int cyc = 0;
  int last_rise = 0;
  int exp_half = 2;
  bit finished = 0;
  logic [15:0] phy_val = 16'h0000;
  logic [1:0]  exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_mgmt_ctrl dut_i (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: drives read data for frame positions 48..63, else pulled high
  assign mdio_i = (rise_cnt >= 48 && rise_cnt <= 63) ? phy_val[63 - rise_cnt] : 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compares every MDC rising edge against the scoreboard
  always @(posedge mdc) begin
    logic [1:0] obs;
    obs = mdio_oe ? {1'b0, mdio_o} : 2'd2;
    if (rise_cnt > 0) chk("R2 mdc period", cyc - last_rise, 2 * exp_half);
    last_rise = cyc;
    if (exp_q.size() == 0) begin
      chk("R9 unexpected mdc edge", 32'd1, 32'd0);
    end else begin
      chk("R1/R3 frame bit", {30'd0, obs}, {30'd0, exp_q.pop_front()});
    end
    rise_cnt++;
  end

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  task automatic push_frame(input logic [31:0] w);
    bit rd;
    rd = (w[29:28] == 2'b10);
    for (int i = 0; i < 32; i++) exp_q.push_back(2'd1);
    for (int b = 31; b >= 0; b--)
      exp_q.push_back((rd && b <= 17) ? 2'd2 : {1'b0, w[b]});
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk);
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic launch(input logic [31:0] w, input int half);
    exp_half = half;
    rise_cnt = 0;
    push_frame(w);
    csr_write(2'd0, w);
  endtask

  task automatic wait_event(input string req);
    logic [31:0] r;
    int n;
    n = 0;
    r = '0;
    while (r[23] !== 1'b1 && n < 4000) begin
      csr_read(2'd1, r);
      n++;
    end
    chk(req, r, 32'h0080_0000);
    chk("R1 all frame bits seen", exp_q.size(), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fail_cnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, wa, wb, wc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11 reset state, R10 readback
    chk("R11 mdc low", {31'd0, mdc}, 0);
    chk("R11 oe low", {31'd0, mdio_oe}, 0);
    csr_read(2'd0, r); chk("R11 data zero", r, 0);
    csr_read(2'd1, r); chk("R11 event zero", r, 0);
    csr_read(2'd2, r); chk("R11 speed default", r, 32'd4);
    csr_write(2'd2, 32'd3 << 1);
    csr_read(2'd2, r); chk("R10 speed readback", r, 32'd6);

    // R1 R5 R6: write frame
    wa = mk(2'b01, 5'h05, 5'h0A, 16'hA5C3);
    launch(wa, 3);
    wait_event("R6 event after write frame");
    csr_read(2'd0, r); chk("R5 data kept", r, wa);

    // R7 clear semantics
    csr_write(2'd1, 32'h0000_0000);
    csr_read(2'd1, r); chk("R7 zero write no effect", r, 32'h0080_0000);
    csr_write(2'd1, 32'h0080_0000);
    csr_read(2'd1, r); chk("R7 clear", r, 0);

    // R3 R4: read frame
    phy_val = 16'h3C96;
    wb = mk(2'b10, 5'h1F, 5'h01, 16'h1234);
    launch(wb, 3);
    wait_event("R6 event after read frame");
    csr_read(2'd0, r); chk("R4 read data", r, {wb[31:16], 16'h3C96});
    csr_write(2'd1, 32'h0080_0000);

    // R9: write while busy ignored
    wc = mk(2'b01, 5'h11, 5'h12, 16'h0F0F);
    launch(wc, 3);
    repeat (50) @(posedge clk);
    csr_write(2'd0, mk(2'b10, 5'h02, 5'h03, 16'hFFFF));
    wait_event("R9 event single frame");
    csr_read(2'd0, r); chk("R9 data unchanged", r, wc);
    repeat (40) @(posedge clk);
    chk("R9 no second frame", exp_q.size(), 0);
    csr_write(2'd1, 32'h0080_0000);

    // R2 zero divider, R8 set/clear collision
    csr_write(2'd2, 32'd0);
    csr_read(2'd2, r); chk("R10 speed zero readback", r, 0);
    wa = mk(2'b01, 5'h00, 5'h1F, 16'h8001);
    exp_half = 1;
    rise_cnt = 0;
    push_frame(wa);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = 2'd0; csr_wdata = wa;
    @(posedge clk);
    @(negedge clk) csr_wr = 1'b0;
    repeat (127) @(posedge clk);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = 2'd1; csr_wdata = 32'h0080_0000;
    @(posedge clk);
    @(negedge clk) csr_wr = 1'b0;
    chk("R2 mdc low after frame", {31'd0, mdc}, 0);
    chk("R3 oe low after frame", {31'd0, mdio_oe}, 0);
    chk("R1 all collision frame bits", exp_q.size(), 0);
    csr_read(2'd1, r); chk("R8 set wins", r, 32'h0080_0000);
    csr_write(2'd1, 32'h0080_0000);
    csr_read(2'd1, r); chk("R7 clear after collision", r, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end
endmodule